// File: doc/BRIEF.md
# Interrupt Priority Selector

This block chooses, for each interrupt-target context, the single source that should be serviced next. All contexts share the pending and claimed bit vectors and the per-source priority array. Each context has its own enable vector and its own priority threshold. A source can be chosen only if it is pending, not claimed and enabled for that context. Its priority must also be strictly greater than the context's threshold. When several sources reach the same top priority, the one with the smallest ID is chosen.

The bit vectors arrive as whole 32-bit words. When the source count does not fill the last word, the unused upper bits carry no meaning. Source ID 0 is reserved: an ID of zero on the output means that nothing qualifies. For each context the block returns the chosen ID and a level request toward the processor context. Both outputs are registered, so they follow the inputs one clock later.

Top module: `irq_best_pick`

## Requirements
- R1: A source takes part in selection only when its pending bit is 1, its claimed bit is 0 and the context's enable bit for it is 1. The bit for source i is bit i of each flat vector.
- R2: A source whose priority equals or is below the context threshold is never selected. Only a priority strictly greater than the threshold can win.
- R3: Among the qualifying sources, the one with the highest priority is reported. Source i's priority is `prio_flat[i*PRIO_W +: PRIO_W]`.
- R4: When several qualifying sources share the highest priority, the smallest ID among them is reported.
- R5: The reported ID is 0 when no source qualifies. Source 0 is never a candidate, whatever its bits and priority.
- R6: Bits of the word vectors at positions NSRC and above do not affect either output.
- R7: Each context's `irq_req` bit is 1 exactly when that context's reported ID is nonzero.
- R8: During reset both outputs are 0. After reset, the outputs reflect the inputs as they stood at the previous rising clock edge.
- R9: Each context uses only its own enable slice and threshold slice. A change to one context's enable or threshold leaves the other contexts' outputs unchanged.
- R10: A source with priority 0 is never selected, even with a threshold of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_words | input | 32*ceil(NSRC/32) | Pending bit per source |
| claim_words | input | 32*ceil(NSRC/32) | Claimed (in service) bit per source |
| en_words | input | NCTX*32*ceil(NSRC/32) | Enable vector per context; context c occupies slice c |
| prio_flat | input | NSRC*PRIO_W | Priority per source, source i at bits i*PRIO_W |
| thresh_flat | input | NCTX*PRIO_W | Threshold per context |
| win_id | output | NCTX*clog2(NSRC) | Registered winning ID per context, 0 for none |
| irq_req | output | NCTX | Registered interrupt request per context |

## Verification
The bench targets the following corner cases:
- **Threshold equality.** A design that compared with greater-or-equal would raise a request for a source sitting exactly at the threshold.
- **Ties.** Equal-priority sources are placed in different words. A merge that favoured the right-hand child would report the higher ID.
- **Source 0 and the tail bits.** Source 0 and the bits past the last real source are driven pending and enabled. Mistakes here would show up as either a spurious nonzero result or as an ID that does not exist.
- **Context independence and latency.** Each context is given a different enable and threshold; sliced wrongly, one context would echo the other. The bench also checks the old output just after each input change, which catches a design that passed results through without registering them.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int WORD_BITS = 32;

  // bits needed to hold n sources as whole words
  function automatic int vec_bits(input int n);
    return ((n + WORD_BITS - 1) / WORD_BITS) * WORD_BITS;
  endfunction

  // width of a source ID
  function automatic int id_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // leaves of the comparison tree: next power of two
  function automatic int tree_leaves(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/irqsel_cand.sv
module irqsel_cand #(
  parameter int NSRC = 64,
  parameter int VB   = irqsel_pkg::vec_bits(NSRC)
) (
  input  logic [VB-1:0]   pend,
  input  logic [VB-1:0]   claim,
  input  logic [VB-1:0]   en,
  output logic [NSRC-1:0] cand
);
  // only bits below NSRC are looked at; source 0 is reserved
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (i == 0) begin : g_rsv
      assign cand[i] = 1'b0;
    end else begin : g_src
      assign cand[i] = pend[i] & ~claim[i] & en[i];
    end
  end

  logic unused_tail;
  if (VB > NSRC) begin : g_tail
    assign unused_tail = ^{pend[VB-1:NSRC], claim[VB-1:NSRC], en[VB-1:NSRC]};
  end else begin : g_notail
    assign unused_tail = 1'b0;
  end
endmodule

// File: rtl/irqsel_tree.sv
module irqsel_tree #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int IDW    = irqsel_pkg::id_bits(NSRC)
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   best_ok,
  output logic [PRIO_W-1:0]      best_prio,
  output logic [IDW-1:0]         best_id
);
  localparam int LEAVES = irqsel_pkg::tree_leaves(NSRC);
  localparam int NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDW-1:0]    ni [NODES];

  // leaves sit at LEAVES-1+i, in ascending ID order from left to right
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NSRC) begin : g_real
      assign nv[LEAVES-1+i] = cand[i];
      assign np[LEAVES-1+i] = prio_flat[i*PRIO_W +: PRIO_W];
      assign ni[LEAVES-1+i] = IDW'(i);
    end else begin : g_pad
      assign nv[LEAVES-1+i] = 1'b0;
      assign np[LEAVES-1+i] = '0;
      assign ni[LEAVES-1+i] = '0;
    end
  end

  // inner node k merges children 2k+1 (lower IDs) and 2k+2 (higher IDs);
  // the right child wins only when strictly better, so ties keep the lower ID
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] > np[2*k+1]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
  end

  assign best_ok   = nv[0];
  assign best_prio = np[0];
  assign best_id   = ni[0];
endmodule

// File: rtl/irqsel_ctx.sv
module irqsel_ctx #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int IDW    = irqsel_pkg::id_bits(NSRC),
  parameter int VB     = irqsel_pkg::vec_bits(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VB-1:0]          pend,
  input  logic [VB-1:0]          claim,
  input  logic [VB-1:0]          en,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      thr,
  output logic [IDW-1:0]         win_q,
  output logic                   irq_q
);
  logic [NSRC-1:0]   cand_vec;
  logic              best_ok;
  logic [PRIO_W-1:0] best_prio;
  logic [IDW-1:0]    best_id;
  logic              sel_hit;
  logic [IDW-1:0]    sel_id;

  irqsel_cand #(.NSRC(NSRC), .VB(VB)) u_cand (
    .pend(pend), .claim(claim), .en(en), .cand(cand_vec)
  );

  irqsel_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_tree (
    .cand(cand_vec), .prio_flat(prio_flat),
    .best_ok(best_ok), .best_prio(best_prio), .best_id(best_id)
  );

  // the best candidate must clear the threshold strictly
  assign sel_hit = best_ok && (best_prio > thr);
  assign sel_id  = sel_hit ? best_id : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      win_q <= sel_id;
      irq_q <= sel_hit;
    end
  end

  function automatic logic [PRIO_W-1:0] prio_at(input logic [NSRC*PRIO_W-1:0] f,
                                                input logic [IDW-1:0] id);
    return (int'(id) < NSRC) ? f[int'(id)*PRIO_W +: PRIO_W] : '0;
  endfunction

  function automatic logic cand_at(input logic [NSRC-1:0] v, input logic [IDW-1:0] id);
    return (int'(id) < NSRC) ? v[id] : 1'b0;
  endfunction

  // R2
  win_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> (prio_at($past(prio_flat), win_q) > $past(thr)));

  // R1
  won_was_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> cand_at($past(cand_vec), win_q));

  // R5
  idle_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vec == '0) |=> (win_q == '0));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (win_q != '0));
endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int NCTX   = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [irqsel_pkg::vec_bits(NSRC)-1:0]         pend_words,
  input  logic [irqsel_pkg::vec_bits(NSRC)-1:0]         claim_words,
  input  logic [NCTX*irqsel_pkg::vec_bits(NSRC)-1:0]    en_words,
  input  logic [NSRC*PRIO_W-1:0]                        prio_flat,
  input  logic [NCTX*PRIO_W-1:0]                        thresh_flat,
  output logic [NCTX*irqsel_pkg::id_bits(NSRC)-1:0]     win_id,
  output logic [NCTX-1:0]                               irq_req
);
  localparam int VB  = irqsel_pkg::vec_bits(NSRC);
  localparam int IDW = irqsel_pkg::id_bits(NSRC);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irqsel_ctx #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW), .VB(VB)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend_words),
      .claim    (claim_words),
      .en       (en_words[c*VB +: VB]),
      .prio_flat(prio_flat),
      .thr      (thresh_flat[c*PRIO_W +: PRIO_W]),
      .win_q    (win_id[c*IDW +: IDW]),
      .irq_q    (irq_req[c])
    );
  end
endmodule

// File: tb/sim_irq_best_pick.sv
module sim_irq_best_pick;
  localparam int NSRC = 45;
  localparam int PW   = 3;
  localparam int NCTX = 2;
  localparam int VB   = 64;
  localparam int IDW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VB-1:0]      pend = '0;
  logic [VB-1:0]      clm  = '0;
  logic [NCTX*VB-1:0] en   = '0;
  logic [NSRC*PW-1:0] prio = '0;
  logic [NCTX*PW-1:0] thr  = '0;
  logic [NCTX*IDW-1:0] win;
  logic [NCTX-1:0]     irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R8";
  int last_exp [NCTX];

  always #5 clk = ~clk;

  irq_best_pick #(.NSRC(NSRC), .PRIO_W(PW), .NCTX(NCTX)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_words(pend), .claim_words(clm),
    .en_words(en), .prio_flat(prio), .thresh_flat(thr),
    .win_id(win), .irq_req(irq)
  );

  // behavioural reference: ascending scan, strict comparison from the threshold
  function automatic int model_id(input int c);
    int best, id;
    best = int'(thr[c*PW +: PW]);
    id = 0;
    for (int i = 1; i < NSRC; i++) begin
      if (pend[i] && !clm[i] && en[c*VB + i] && int'(prio[i*PW +: PW]) > best) begin
        best = int'(prio[i*PW +: PW]);
        id = i;
      end
    end
    return id;
  endfunction

  task automatic check(input int c, input int exp_id, input string t);
    int got;
    got = int'(win[c*IDW +: IDW]);
    checks++;
    if (got != exp_id) begin
      errors++;
      $display("FAIL %s ctx%0d id actual=%0d expected=%0d", t, c, got, exp_id);
    end
    checks++;
    if (irq[c] != (exp_id != 0)) begin
      errors++;
      $display("FAIL R7 (%s) ctx%0d irq actual=%0b expected=%0b", t, c, irq[c], exp_id != 0);
    end
  endtask

  // inputs were just changed: outputs hold old values until the next edge (R8),
  // then match the model on the new inputs
  task automatic tick();
    #1;
    for (int c = 0; c < NCTX; c++) check(c, last_exp[c], "R8");
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCTX; c++) begin
      last_exp[c] = model_id(c);
      check(c, last_exp[c], tag);
    end
  endtask

  task automatic clear_all();
    pend = '0; clm = '0; en = '0; prio = '0; thr = '0;
  endtask

  task automatic set_src(input int i, input int p, input int c);
    pend[i] = 1'b1;
    en[c*VB + i] = 1'b1;
    prio[i*PW +: PW] = PW'(p);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCTX; c++) last_exp[c] = 0;
    repeat (3) @(negedge clk);
    tag = "R8";
    for (int c = 0; c < NCTX; c++) check(c, 0, "R8");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: pending but disabled, then enabled, then claimed
    tag = "R1";
    clear_all();
    pend[5] = 1'b1; prio[5*PW +: PW] = 3'd4;
    tick(); check(0, 0, "R1");
    en[5] = 1'b1;
    tick(); check(0, 5, "R1");
    clm[5] = 1'b1;
    tick(); check(0, 0, "R1");

    // R2: priority equal to threshold loses, one above wins
    tag = "R2";
    clear_all();
    set_src(12, 3, 0); thr[0 +: PW] = 3'd3;
    tick(); check(0, 0, "R2");
    thr[0 +: PW] = 3'd2;
    tick(); check(0, 12, "R2");

    // R3: highest priority across words
    tag = "R3";
    clear_all();
    set_src(7, 2, 0); set_src(30, 6, 0); set_src(40, 4, 0);
    tick(); check(0, 30, "R3");

    // R4: tie goes to the lower ID
    tag = "R4";
    clear_all();
    set_src(33, 5, 0); set_src(9, 5, 0); set_src(20, 2, 0);
    tick(); check(0, 9, "R4");

    // R5: source 0 never a candidate
    tag = "R5";
    clear_all();
    set_src(0, 7, 0);
    tick(); check(0, 0, "R5");

    // R6: bits past the last source ignored; last real source still usable
    tag = "R6";
    clear_all();
    pend[50] = 1'b1; en[50] = 1'b1; pend[63] = 1'b1; en[63] = 1'b1;
    tick(); check(0, 0, "R6");
    set_src(44, 1, 0);
    tick(); check(0, 44, "R6");

    // R9: contexts see only their own enable and threshold
    tag = "R9";
    clear_all();
    set_src(3, 5, 0); set_src(4, 2, 1);
    tick(); check(0, 3, "R9"); check(1, 4, "R9");
    thr[PW +: PW] = 3'd2;
    tick(); check(0, 3, "R9"); check(1, 0, "R9");

    // R10: priority 0 never wins at threshold 0
    tag = "R10";
    clear_all();
    set_src(17, 0, 0); set_src(17, 0, 1);
    tick(); check(0, 0, "R10"); check(1, 0, "R10");

    // R3: random patterns, tail bits included
    tag = "R3";
    for (int n = 0; n < 300; n++) begin
      pend = {$urandom, $urandom};
      clm  = {$urandom, $urandom} & {$urandom, $urandom};
      en   = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < NSRC; i++) prio[i*PW +: PW] = PW'($urandom);
      thr = (NCTX*PW)'($urandom);
      if (n % 4 == 0) thr = '0;
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule